// File: doc/BRIEF.md
# Configurable Asynchronous Serial Framer

This block is the character engine of an asynchronous serial port. A transmitter takes one character at a time through a valid/ready holding register and shifts it onto a single line. A receiver oversamples an incoming line and rebuilds characters from it. A 7-bit line-control word, which may change between characters, selects the frame format:

- the character length;
- the stop-bit count;
- whether a parity bit is present, and which kind;
- a break override on the transmit line.

The serial clocking comes from a one-cycle enable pulse at sixteen times the baud rate (parameter `OVS`). Divisor logic and character queues sit outside the block. A transmit-enable input lets flow-control logic hold the transmitter between characters. Two flags report the transmit side: one shows that the holding register is empty, the other that the whole transmit path is empty. Each received character comes out with a one-cycle valid pulse, together with its parity-error, framing-error and break flags.

Top module: `async_serial_framer`

## Requirements
- R1: The idle line is high. A frame is one low start bit, then the data bits sent least-significant first, then any parity bit and the stop bits (high). The character length is 5 + `lcr[1:0]` bits, and received characters are right-justified with the upper bits zero.
- R2: With `lcr[2]`=0 the stop period is one bit time. With `lcr[2]`=1 it is two bit times, or one and a half when the length is 5. The next start bit does not begin before the stop period ends.
- R3: When `lcr[3]`=1 a parity bit follows the data. `lcr[5:4]` selects its value: 00 makes the total count of ones odd, 01 makes it even, 10 gives a constant 1 and 11 gives a constant 0.
- R4: While `lcr[6]`=1, `txd` is low from the next clock cycle on, whatever the transmitter is doing.
- R5: While `tx_en`=0, no new character leaves the holding register and the line stays idle. A character already being shifted completes normally.
- R6: `tx_ready` and `hold_empty` are high exactly when the holding register is empty. `shift_empty` is high only when the holding register is empty and no frame is in progress. All three are high after reset.
- R7: The receiver confirms a start bit half a bit time after the falling edge. A low pulse shorter than that is ignored and produces no character.
- R8: `rx_parity_err` is set when parity is enabled and the received parity bit differs from the value that R3 gives for the received data.
- R9: `rx_frame_err` is set when the first stop bit is sampled low. `rx_break` is set when every sampled bit of the frame, including that stop bit, is low. After a low stop bit the receiver waits for the line to return high before it looks for a new start.
- R10: `rx_valid` is a single-cycle pulse, one per received frame, given at the middle of the first stop bit. The data and flags are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at OVS times the baud rate |
| lcr | input | 7 | Line-control word: length, stop, parity enable, parity kind, break |
| tx_en | input | 1 | Transmit enable gate |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Holding register can accept |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Received character, right-justified |
| rx_valid | output | 1 | One-cycle pulse when a character is complete |
| rx_parity_err | output | 1 | Parity mismatch for this character |
| rx_frame_err | output | 1 | First stop bit was low |
| rx_break | output | 1 | Whole frame was low |
| hold_empty | output | 1 | Holding register empty |
| shift_empty | output | 1 | Nothing left in the transmit path |

## Verification
Two things can coincide: the transmitter loading a character into its shifter, and the receiver finishing a character or the flow-control gate being dropped. The bench provokes this in three ways:
- It runs an independent received frame while a transmitted pair is shifting.
- It loops `txd` back into `rxd`, so that the receiver's stop-bit decision falls inside the transmitter's stop period just before the next load.
- It drops `tx_en` in the middle of a character while a second character waits in the holding register.

Each side is judged separately. A queue of expected received characters is compared at every `rx_valid`, and the line is sampled at mid-bit against frames computed from the requirements. Gaps between start edges are measured to confirm the stop periods.

// File: rtl/serial_framer_pkg.sv
package serial_framer_pkg;

   typedef enum logic [1:0] {
      PAR_ODD  = 2'b00,
      PAR_EVEN = 2'b01,
      PAR_ONE  = 2'b10,
      PAR_ZERO = 2'b11
   } par_mode_e;

   typedef struct packed {
      logic      brk;
      par_mode_e pmode;
      logic      pen;
      logic      stop2;
      logic [1:0] len;
   } line_ctl_t;

   // Parity value for a character of 5 + len bits under the given mode.
   function automatic logic par_calc(input logic [7:0] d, input logic [1:0] len,
                                     input par_mode_e m);
      logic [7:0] mask;
      logic       x;
      mask = 8'hFF >> (2'd3 - len);
      x    = ^(d & mask);
      case (m)
         PAR_ODD:  par_calc = ~x;
         PAR_EVEN: par_calc = x;
         PAR_ONE:  par_calc = 1'b1;
         default:  par_calc = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/sf_tx.sv
module sf_tx
   import serial_framer_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  line_ctl_t ctl,
   input  logic      tx_en,
   input  logic [7:0] tx_data,
   input  logic      tx_valid,
   output logic      tx_ready,
   output logic      txd,
   output logic      hold_empty,
   output logic      shift_empty
);

   localparam int CW = $clog2(2 * OVS + 1);
   localparam logic [CW-1:0] BIT_END  = CW'(OVS - 1);
   localparam logic [CW-1:0] STOP_1   = CW'(OVS - 1);
   localparam logic [CW-1:0] STOP_1H  = CW'(OVS + OVS / 2 - 1);
   localparam logic [CW-1:0] STOP_2   = CW'(2 * OVS - 1);

   typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_e;

   tst_e       st;
   logic [CW-1:0] cnt;
   logic [2:0] bit_idx;
   logic [7:0] hold_q, sh;
   logic       hold_full;
   logic [1:0] f_len;
   logic       f_stop2, f_pen;
   par_mode_e  f_pm;
   logic       txd_q;
   logic       line_bit;
   logic [2:0] last_idx;
   logic [CW-1:0] stop_end;

   assign last_idx = {1'b0, f_len} + 3'd4;
   assign stop_end = !f_stop2 ? STOP_1 : ((f_len == 2'd0) ? STOP_1H : STOP_2);

   always_comb begin
      case (st)
         T_START: line_bit = 1'b0;
         T_DATA:  line_bit = sh[bit_idx];
         T_PAR:   line_bit = par_calc(sh, f_len, f_pm);
         default: line_bit = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= T_IDLE;
         cnt       <= '0;
         bit_idx   <= '0;
         hold_q    <= '0;
         sh        <= '0;
         hold_full <= 1'b0;
         f_len     <= '0;
         f_stop2   <= 1'b0;
         f_pen     <= 1'b0;
         f_pm      <= PAR_ODD;
         txd_q     <= 1'b1;
      end else begin
         txd_q <= ctl.brk ? 1'b0 : line_bit;
         if (tx_valid && !hold_full) begin
            hold_q    <= tx_data;
            hold_full <= 1'b1;
         end
         case (st)
            T_IDLE: begin
               if (hold_full && tx_en) begin
                  sh        <= hold_q;
                  hold_full <= 1'b0;
                  f_len     <= ctl.len;
                  f_stop2   <= ctl.stop2;
                  f_pen     <= ctl.pen;
                  f_pm      <= ctl.pmode;
                  cnt       <= '0;
                  st        <= T_START;
               end
            end
            T_START: if (tick) begin
               if (cnt == BIT_END) begin
                  cnt     <= '0;
                  bit_idx <= '0;
                  st      <= T_DATA;
               end else cnt <= cnt + 1'b1;
            end
            T_DATA: if (tick) begin
               if (cnt == BIT_END) begin
                  cnt <= '0;
                  if (bit_idx == last_idx) st <= f_pen ? T_PAR : T_STOP;
                  else bit_idx <= bit_idx + 3'd1;
               end else cnt <= cnt + 1'b1;
            end
            T_PAR: if (tick) begin
               if (cnt == BIT_END) begin
                  cnt <= '0;
                  st  <= T_STOP;
               end else cnt <= cnt + 1'b1;
            end
            default: if (tick) begin
               if (cnt == stop_end) begin
                  cnt <= '0;
                  st  <= T_IDLE;
               end else cnt <= cnt + 1'b1;
            end
         endcase
      end
   end

   assign txd         = txd_q;
   assign tx_ready    = !hold_full;
   assign hold_empty  = !hold_full;
   assign shift_empty = !hold_full && (st == T_IDLE);

   // R4: break forces the line low one cycle later
   p_break_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.brk |=> !txd);

   // R5: with the gate closed an idle shifter stays idle
   p_gate_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == T_IDLE && !tx_en) |=> (st == T_IDLE));

   // R6: an accepted character makes the holding register non-empty
   p_accept_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !hold_empty);

   // R2: the line is high throughout the stop period unless break is set
   p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == T_STOP && $past(st) == T_STOP && !$past(ctl.brk)) |-> txd);

endmodule

// File: rtl/sf_rx.sv
module sf_rx
   import serial_framer_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] len,
   input  logic       pen,
   input  par_mode_e  pmode,
   input  logic       rxd,
   output logic [7:0] rx_data,
   output logic       rx_valid,
   output logic       rx_parity_err,
   output logic       rx_frame_err,
   output logic       rx_break
);

   localparam int CW = $clog2(2 * OVS + 1);
   localparam logic [CW-1:0] BIT_END = CW'(OVS - 1);
   localparam logic [CW-1:0] MID_END = CW'(OVS / 2 - 1);

   typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_WAIT} rst_e;

   logic rx_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq <= '1;
            else        sq <= (sq << 1) | SYNC_STAGES'(rxd);
         end
         assign rx_s = sq[SYNC_STAGES-1];
      end
   endgenerate

   rst_e       st;
   logic [CW-1:0] cnt;
   logic [2:0] bit_idx;
   logic [7:0] sh;
   logic       par_q;
   logic [1:0] f_len;
   logic       f_pen;
   par_mode_e  f_pm;
   logic [2:0] last_idx;

   assign last_idx = {1'b0, f_len} + 3'd4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= R_IDLE;
         cnt           <= '0;
         bit_idx       <= '0;
         sh            <= '0;
         par_q         <= 1'b0;
         f_len         <= '0;
         f_pen         <= 1'b0;
         f_pm          <= PAR_ODD;
         rx_data       <= '0;
         rx_valid      <= 1'b0;
         rx_parity_err <= 1'b0;
         rx_frame_err  <= 1'b0;
         rx_break      <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         case (st)
            R_IDLE: if (tick && !rx_s) begin
               st    <= R_START;
               cnt   <= '0;
               sh    <= '0;
               par_q <= 1'b0;
               f_len <= len;
               f_pen <= pen;
               f_pm  <= pmode;
            end
            R_START: if (tick) begin
               if (cnt == MID_END) begin
                  cnt     <= '0;
                  bit_idx <= '0;
                  st      <= rx_s ? R_IDLE : R_DATA;
               end else cnt <= cnt + 1'b1;
            end
            R_DATA: if (tick) begin
               if (cnt == BIT_END) begin
                  cnt         <= '0;
                  sh[bit_idx] <= rx_s;
                  if (bit_idx == last_idx) st <= f_pen ? R_PAR : R_STOP;
                  else bit_idx <= bit_idx + 3'd1;
               end else cnt <= cnt + 1'b1;
            end
            R_PAR: if (tick) begin
               if (cnt == BIT_END) begin
                  cnt   <= '0;
                  par_q <= rx_s;
                  st    <= R_STOP;
               end else cnt <= cnt + 1'b1;
            end
            R_STOP: if (tick) begin
               if (cnt == BIT_END) begin
                  cnt           <= '0;
                  rx_valid      <= 1'b1;
                  rx_data       <= sh;
                  rx_parity_err <= f_pen && (par_q != par_calc(sh, f_len, f_pm));
                  rx_frame_err  <= !rx_s;
                  rx_break      <= !rx_s && (sh == 8'h00) && (!f_pen || !par_q);
                  st            <= rx_s ? R_IDLE : R_WAIT;
               end else cnt <= cnt + 1'b1;
            end
            default: if (rx_s) st <= R_IDLE;
         endcase
      end
   end

   // R10: a completed character is reported for exactly one cycle
   p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R9: a break frame is always also a framing error
   p_break_is_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_break) |-> rx_frame_err);

   // R7: data collection starts only after a low mid-start sample
   p_start_confirmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == R_START && st == R_DATA) |-> !$past(rx_s));

endmodule

// File: rtl/async_serial_framer.sv
module async_serial_framer
   import serial_framer_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic [6:0] lcr,
   input  logic       tx_en,
   input  logic [7:0] tx_data,
   input  logic       tx_valid,
   output logic       tx_ready,
   output logic       txd,
   input  logic       rxd,
   output logic [7:0] rx_data,
   output logic       rx_valid,
   output logic       rx_parity_err,
   output logic       rx_frame_err,
   output logic       rx_break,
   output logic       hold_empty,
   output logic       shift_empty
);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be an even value of at least 4");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie between 0 and 4");
   end

   line_ctl_t ctl;
   assign ctl = line_ctl_t'(lcr);

   sf_tx #(.OVS(OVS)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick16),
      .ctl         (ctl),
      .tx_en       (tx_en),
      .tx_data     (tx_data),
      .tx_valid    (tx_valid),
      .tx_ready    (tx_ready),
      .txd         (txd),
      .hold_empty  (hold_empty),
      .shift_empty (shift_empty)
   );

   sf_rx #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick16),
      .len           (ctl.len),
      .pen           (ctl.pen),
      .pmode         (ctl.pmode),
      .rxd           (rxd),
      .rx_data       (rx_data),
      .rx_valid      (rx_valid),
      .rx_parity_err (rx_parity_err),
      .rx_frame_err  (rx_frame_err),
      .rx_break      (rx_break)
   );

endmodule

// File: tb/async_serial_framer_tb.sv
module async_serial_framer_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick16 = 1'b0;
   logic [6:0] lcr = 7'h03;
   logic tx_en = 1'b1;
   logic [7:0] tx_data = '0;
   logic tx_valid = 1'b0;
   logic tx_ready, txd, rxd;
   logic [7:0] rx_data;
   logic rx_valid, rx_parity_err, rx_frame_err, rx_break, hold_empty, shift_empty;
   logic rxd_drv = 1'b1;
   logic loop = 1'b0;
   logic quiet = 1'b0;
   logic prev_valid = 1'b0;
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   int   div = 0;
   bit   done = 1'b0;

   typedef struct { logic [7:0] d; bit pe; bit fe; bit bk; } rxe_t;
   rxe_t rxq[$];

   always #10 clk = ~clk;

   assign rxd = loop ? txd : rxd_drv;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      div <= (div == 3) ? 0 : div + 1;
      tick16 <= (div == 3);
   end

   async_serial_framer u_dut (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .lcr(lcr), .tx_en(tx_en),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
      .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
      .rx_break(rx_break), .hold_empty(hold_empty), .shift_empty(shift_empty)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit exp_par(input logic [7:0] d, input int n, input logic [6:0] l);
      int ones = 0;
      for (int i = 0; i < n; i++) ones += int'(d[i]);
      case (l[5:4])
         2'b00:   return (ones % 2) == 0;
         2'b01:   return (ones % 2) == 1;
         2'b10:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // Per-clock monitor: receive queue, pulse width, path flags, gate quietness
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(!(shift_empty && !hold_empty), "R6", "shift_empty without hold_empty",
             int'(shift_empty), 0);
         chk(tx_ready === hold_empty, "R6", "tx_ready vs hold_empty",
             int'(tx_ready), int'(hold_empty));
         if (quiet) chk(txd === 1'b1, "R5", "line idle while gated", int'(txd), 1);
         if (rx_valid && prev_valid) chk(1'b0, "R10", "valid longer than one cycle", 2, 1);
         if (rx_valid) begin
            if (rxq.size() == 0) chk(1'b0, "R7", "unexpected character", int'(rx_data), -1);
            else begin
               rxe_t e;
               e = rxq.pop_front();
               chk(rx_data === e.d, "R1", "rx data", int'(rx_data), int'(e.d));
               chk(rx_parity_err === e.pe, "R8", "parity error flag",
                   int'(rx_parity_err), int'(e.pe));
               chk(rx_frame_err === e.fe, "R9", "framing error flag",
                   int'(rx_frame_err), int'(e.fe));
               chk(rx_break === e.bk, "R9", "break flag", int'(rx_break), int'(e.bk));
            end
         end
         prev_valid <= rx_valid;
      end
   end

   task automatic send(input logic [7:0] d);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = d;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic tx_check(input logic [7:0] d, input logic [6:0] l, output int tf);
      int n;
      n = 5 + int'(l[1:0]);
      @(negedge clk);
      while (txd !== 1'b0) @(negedge clk);
      tf = cyc;
      repeat (31) @(negedge clk);
      chk(txd === 1'b0, "R1", "start bit", int'(txd), 0);
      for (int i = 0; i < n; i++) begin
         repeat (64) @(negedge clk);
         chk(txd === d[i], "R1", "data bit", int'(txd), int'(d[i]));
      end
      if (l[3]) begin
         repeat (64) @(negedge clk);
         chk(txd === exp_par(d, n, l), "R3", "parity bit", int'(txd),
             int'(exp_par(d, n, l)));
      end
      repeat (64) @(negedge clk);
      chk(txd === 1'b1, "R2", "first stop bit", int'(txd), 1);
      if (l[2] && n > 5) begin
         repeat (64) @(negedge clk);
         chk(txd === 1'b1, "R2", "second stop bit", int'(txd), 1);
      end
   endtask

   task automatic tx_pair(input logic [7:0] a, input logic [7:0] b, input logic [6:0] l,
                          input int frame_ticks);
      int t1, t2;
      lcr = l;
      fork
         begin send(a); send(b); end
         begin tx_check(a, l, t1); tx_check(b, l, t2); end
      join
      chk((t2 - t1) >= frame_ticks * 4 - 6 && (t2 - t1) <= frame_ticks * 4 + 6,
          "R2", "start-to-start gap", t2 - t1, frame_ticks * 4);
   endtask

   task automatic rx_frame(input logic [7:0] d, input logic [6:0] l, input bit flip,
                           input bit stop_v, input int low_extra);
      int n;
      logic [7:0] m;
      bit p;
      rxe_t e;
      n = 5 + int'(l[1:0]);
      m = d & (8'hFF >> (3 - l[1:0]));
      p = exp_par(d, n, l) ^ flip;
      e.d  = m;
      e.pe = l[3] & flip;
      e.fe = !stop_v;
      e.bk = !stop_v && (m == 8'h00) && (!l[3] || !p);
      rxq.push_back(e);
      rxd_drv = 1'b0;
      repeat (64) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         rxd_drv = d[i];
         repeat (64) @(negedge clk);
      end
      if (l[3]) begin
         rxd_drv = p;
         repeat (64) @(negedge clk);
      end
      rxd_drv = stop_v;
      repeat (64) @(negedge clk);
      if (!stop_v) repeat (low_extra) @(negedge clk);
      rxd_drv = 1'b1;
      repeat (64) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int tf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 reset state
      chk(txd === 1'b1, "R1", "idle line after reset", int'(txd), 1);
      chk(hold_empty === 1'b1, "R6", "hold_empty after reset", int'(hold_empty), 1);
      chk(shift_empty === 1'b1, "R6", "shift_empty after reset", int'(shift_empty), 1);
      chk(tx_ready === 1'b1, "R6", "tx_ready after reset", int'(tx_ready), 1);
      chk(rx_valid === 1'b0, "R10", "no valid after reset", int'(rx_valid), 0);

      // R1/R2: 8 bits, one stop; 5 bits with 1.5 stop
      tx_pair(8'hA5, 8'h3C, 7'h03, 160);
      tx_pair(8'h15, 8'h0A, 7'h04, 120);
      // R3: even parity 6 bits 2 stop, odd 7 bits, forced one, forced zero
      tx_pair(8'h2D, 8'h11, 7'h1D, 160);
      tx_pair(8'h5B, 8'h7F, 7'h0A, 160);
      tx_pair(8'hC4, 8'h00, 7'h2B, 176);
      tx_pair(8'hFF, 8'h81, 7'h3B, 176);

      // R4: break while idle
      lcr = 7'h43;
      repeat (3) @(negedge clk);
      chk(txd === 1'b0, "R4", "break drives line low", int'(txd), 0);
      lcr = 7'h03;
      repeat (3) @(negedge clk);
      chk(txd === 1'b1, "R4", "line back high after break", int'(txd), 1);

      // R5/R6: gate closed before a character arrives
      tx_en = 1'b0;
      send(8'h66);
      quiet = 1'b1;
      repeat (400) @(negedge clk);
      quiet = 1'b0;
      chk(hold_empty === 1'b0, "R6", "hold full while gated", int'(hold_empty), 0);
      chk(shift_empty === 1'b0, "R6", "path not empty while gated", int'(shift_empty), 0);
      tx_en = 1'b1;
      tx_check(8'h66, 7'h03, tf);
      repeat (64) @(negedge clk);
      chk(shift_empty === 1'b1, "R6", "path empty after frame", int'(shift_empty), 1);

      // R5: gate dropped mid-character, second character waits
      fork
         send(8'h81);
         begin repeat (150) @(negedge clk); tx_en = 1'b0; end
         tx_check(8'h81, 7'h03, tf);
      join
      send(8'h42);
      repeat (40) @(negedge clk);
      quiet = 1'b1;
      repeat (400) @(negedge clk);
      quiet = 1'b0;
      chk(hold_empty === 1'b0, "R5", "second character held", int'(hold_empty), 0);
      tx_en = 1'b1;
      tx_check(8'h42, 7'h03, tf);
      repeat (64) @(negedge clk);

      // Receiver: R1 plain and short, R8 parity errors, R9 framing and break, R7 glitch
      lcr = 7'h03;
      rx_frame(8'hC3, 7'h03, 1'b0, 1'b1, 0);
      lcr = 7'h00;
      rx_frame(8'hFF, 7'h00, 1'b0, 1'b1, 0);
      lcr = 7'h1B;
      rx_frame(8'h96, 7'h1B, 1'b1, 1'b1, 0);
      rx_frame(8'h97, 7'h1B, 1'b0, 1'b1, 0);
      lcr = 7'h3A;
      rx_frame(8'h55, 7'h3A, 1'b1, 1'b1, 0);
      lcr = 7'h03;
      rx_frame(8'h5A, 7'h03, 1'b0, 1'b0, 0);
      rx_frame(8'h00, 7'h03, 1'b0, 1'b0, 300);
      rxd_drv = 1'b0;
      repeat (20) @(negedge clk);
      rxd_drv = 1'b1;
      repeat (100) @(negedge clk);
      rx_frame(8'h3E, 7'h03, 1'b0, 1'b1, 0);

      // Concurrent transmit and receive
      fork
         rx_frame(8'h69, 7'h03, 1'b0, 1'b1, 0);
         tx_pair(8'h3A, 8'hB2, 7'h03, 160);
      join

      // Loopback with odd parity, 7 bits
      repeat (100) @(negedge clk);
      lcr  = 7'h0A;
      loop = 1'b1;
      rxq.push_back('{d: 8'h5B, pe: 1'b0, fe: 1'b0, bk: 1'b0});
      rxq.push_back('{d: 8'h24, pe: 1'b0, fe: 1'b0, bk: 1'b0});
      tx_pair(8'h5B, 8'hA4, 7'h0A, 160);
      repeat (200) @(negedge clk);
      loop = 1'b0;
      repeat (100) @(negedge clk);
      chk(rxq.size() == 0, "R10", "every frame reported", rxq.size(), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule